// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device-side manager of a circular ring of transmit descriptors that sits in host memory. Software sets up the ring's base address and its length in slots. It then writes the tail index to hand descriptors over to the device. The engine owns the head index. Whenever its fetch index lags the tail, it reads descriptors one at a time, in ring order, into an eight-entry on-chip queue. It then works through that queue in order.

Two kinds of descriptor are handled. A context descriptor loads a 32-bit offload setting that stays in force for every later buffer until another context descriptor replaces it. A data descriptor names one buffer; the engine asks for that buffer to be fetched and tags the request with the current offload setting. If the descriptor asks for it, the engine then requests a status write-back into the descriptor's own ring slot. After that it retires the slot by moving the head forward. When the retired descriptor closes a packet, it pulses an interrupt. The host bus, the buffer DMA and the write-back itself are reduced to request/acknowledge handshakes.

Descriptor layout (64 bits): bit 63 is the type (1 = context, 0 = data); bit 49 is the status-report flag; bit 48 marks end of packet; bits 47:32 hold the buffer length; bits 31:0 hold the buffer address, or the offload setting in a context descriptor. Each slot is 16 bytes wide, so slot n lives at base + 16·n.

Top module: `txRingEngine`

## Requirements
- R1: After reset the head reads 0, no descriptor read, buffer or write-back request is raised, the interrupt is low and the tail error flag is clear.
- R2: When the tail moves ahead of the fetch index, the engine issues one descriptor read per slot, in ring order, at address base + 16·slot. The slot index wraps from length−1 to 0.
- R3: A tail write with a value not below the ring length is ignored: no reads follow and the head does not move. It sets the tail error flag, and the next in-range tail write clears that flag.
- R4: At most 8 descriptors are held on chip. While 8 are held and none has been retired, no further descriptor read is requested.
- R5: A data descriptor (bit 63 = 0) raises a buffer request that carries its address (bits 31:0), its length (bits 47:32) and its end-of-packet flag (bit 48). The request is held steady until it is acknowledged.
- R6: A context descriptor (bit 63 = 1) raises no buffer request. Its bits 31:0 become the offload setting carried by every later buffer request until the next context descriptor.
- R7: After the buffer acknowledge of a data descriptor with bit 49 set, a write-back request to base + 16·slot is raised and held until acknowledged. A descriptor with bit 49 clear raises no write-back.
- R8: The head advances by exactly one slot for each retired descriptor and wraps from length−1 to 0.
- R9: Retiring a data descriptor with bit 48 set gives a one-cycle interrupt pulse in the cycle after retirement. Descriptors without bit 48 give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baseWrEn | input | 1 | Load ring base address |
| baseIn | input | AW | Ring base byte address |
| lenWrEn | input | 1 | Load ring length; clears head, tail, fetch index and queue |
| lenIn | input | PW | Ring length in slots |
| tailWrEn | input | 1 | Software tail write |
| tailIn | input | PW | New tail index |
| descRdReq | output | 1 | Descriptor read request |
| descRdAddr | output | AW | Byte address of the slot being read |
| descRdAck | input | 1 | Read completes this cycle, data valid |
| descRdData | input | 64 | Returned descriptor |
| bufReq | output | 1 | Buffer fetch request |
| bufAddr | output | 32 | Buffer address |
| bufLen | output | 16 | Buffer length in bytes |
| bufEop | output | 1 | Buffer closes a packet |
| bufCtx | output | 32 | Offload setting in force |
| bufAck | input | 1 | Buffer DMA complete |
| wbReq | output | 1 | Status write-back request |
| wbAddr | output | AW | Ring slot address for write-back |
| wbAck | input | 1 | Write-back complete |
| head | output | PW | Head index |
| tailErr | output | 1 | Last tail write was out of range |
| eopIrq | output | 1 | End-of-packet interrupt pulse |

## Verification
The assertions take it that software changes the ring length only while the engine is idle, and that it only moves the tail forward, never past the head of the slots still in use. Under those conditions the head stepping and the held-request properties are meaningful. The bench configures the length once, before any tail write. Every later tail write it makes either lies outside the ring or advances the tail by fewer slots than the ring holds, including one that wraps past slot 0. A stalled buffer acknowledge fills the queue without breaking those rules.

// File: rtl/txRingPkg.sv
package txRingPkg;

  typedef struct packed {
    logic        isCtx;
    logic [12:0] spare;
    logic        rptStat;
    logic        eop;
    logic [15:0] len;
    logic [31:0] addr;
  } txDesc_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic headInc;
    logic ctxLoad;
    logic pktDone;
  } txStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUF  = 2'd1,
    S_WB   = 2'd2
  } txState_t;

endpackage

// File: rtl/txRingData.sv
module txRingData
  import txRingPkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int QD = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          baseWrEn,
  input  logic [AW-1:0] baseIn,
  input  logic          lenWrEn,
  input  logic [PW-1:0] lenIn,
  input  logic          tailWrEn,
  input  logic [PW-1:0] tailIn,
  input  txDesc_t       rdDesc,
  input  txStrobe_t     stb,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] wbAddr,
  output logic [PW-1:0] headIdx,
  output logic [PW-1:0] ringLen,
  output logic          fetchNeed,
  output logic          qFull,
  output logic          qEmpty,
  output logic [$clog2(QD):0] qCount,
  output txDesc_t       qHead,
  output logic [31:0]   ctxSetting,
  output logic          tailErr,
  output logic          eopIrq
);
  localparam int QW  = $clog2(QD);
  localparam int DSH = 4;

  logic [AW-1:0] baseQ;
  logic [PW-1:0] tailQ, fetchQ;
  logic [QW-1:0] wrIdx, rdIdx;
  txDesc_t       qMem [QD];

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return (p == n - 1'b1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ      <= '0;
      ringLen    <= '0;
      headIdx    <= '0;
      tailQ      <= '0;
      fetchQ     <= '0;
      tailErr    <= 1'b0;
      eopIrq     <= 1'b0;
      ctxSetting <= '0;
    end else begin
      eopIrq <= stb.pktDone;
      if (baseWrEn) baseQ <= baseIn;
      if (stb.ctxLoad) ctxSetting <= qHead.addr;
      if (lenWrEn) begin
        ringLen <= lenIn;
        headIdx <= '0;
        tailQ   <= '0;
        fetchQ  <= '0;
        tailErr <= 1'b0;
      end else begin
        if (tailWrEn) begin
          if (tailIn < ringLen) begin
            tailQ   <= tailIn;
            tailErr <= 1'b0;
          end else begin
            tailErr <= 1'b1;
          end
        end
        if (stb.push)    fetchQ  <= stepPtr(fetchQ, ringLen);
        if (stb.headInc) headIdx <= stepPtr(headIdx, ringLen);
      end
    end
  end

  // in-order descriptor queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx  <= '0;
      rdIdx  <= '0;
      qCount <= '0;
    end else if (lenWrEn) begin
      wrIdx  <= '0;
      rdIdx  <= '0;
      qCount <= '0;
    end else begin
      if (stb.push) wrIdx <= wrIdx + 1'b1;
      if (stb.pop)  rdIdx <= rdIdx + 1'b1;
      qCount <= qCount + {{QW{1'b0}}, stb.push} - {{QW{1'b0}}, stb.pop};
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !lenWrEn) qMem[wrIdx] <= rdDesc;
  end

  assign qHead     = qMem[rdIdx];
  assign qFull     = (qCount == (QW+1)'(QD));
  assign qEmpty    = (qCount == '0);
  assign fetchNeed = (fetchQ != tailQ);
  assign rdAddr    = baseQ + (AW'(fetchQ) << DSH);
  assign wbAddr    = baseQ + (AW'(headIdx) << DSH);

endmodule

// File: rtl/txRingCtrl.sv
module txRingCtrl
  import txRingPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flush,
  input  logic      fetchNeed,
  input  logic      qFull,
  input  logic      qEmpty,
  input  txDesc_t   qHead,
  input  logic      rdAck,
  input  logic      bufAck,
  input  logic      wbAck,
  output logic      rdReq,
  output logic      bufReq,
  output logic      wbReq,
  output txStrobe_t stb
);
  txState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    bufReq    = 1'b0;
    wbReq     = 1'b0;
    rdReq     = fetchNeed && !qFull;
    stb.push  = rdReq && rdAck;
    unique case (state)
      S_IDLE: begin
        if (!qEmpty) begin
          if (qHead.isCtx) begin
            stb.ctxLoad = 1'b1;
            stb.pop     = 1'b1;
          end else begin
            nextState = S_BUF;
          end
        end
      end
      S_BUF: begin
        bufReq = 1'b1;
        if (bufAck) begin
          if (qHead.rptStat) begin
            nextState = S_WB;
          end else begin
            stb.pop     = 1'b1;
            stb.pktDone = qHead.eop;
            nextState   = S_IDLE;
          end
        end
      end
      S_WB: begin
        wbReq = 1'b1;
        if (wbAck) begin
          stb.pop     = 1'b1;
          stb.pktDone = qHead.eop;
          nextState   = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
    stb.headInc = stb.pop;
    if (flush) nextState = S_IDLE;
  end

endmodule

// File: rtl/txRingEngine.sv
module txRingEngine
  import txRingPkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int QD = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          baseWrEn,
  input  logic [AW-1:0] baseIn,
  input  logic          lenWrEn,
  input  logic [PW-1:0] lenIn,
  input  logic          tailWrEn,
  input  logic [PW-1:0] tailIn,
  output logic          descRdReq,
  output logic [AW-1:0] descRdAddr,
  input  logic          descRdAck,
  input  logic [63:0]   descRdData,
  output logic          bufReq,
  output logic [31:0]   bufAddr,
  output logic [15:0]   bufLen,
  output logic          bufEop,
  output logic [31:0]   bufCtx,
  input  logic          bufAck,
  output logic          wbReq,
  output logic [AW-1:0] wbAddr,
  input  logic          wbAck,
  output logic [PW-1:0] head,
  output logic          tailErr,
  output logic          eopIrq
);
  localparam int QW = $clog2(QD);

  txStrobe_t     stb;
  txDesc_t       qHead;
  logic          fetchNeed, qFull, qEmpty;
  logic [PW-1:0] ringLen;
  logic [QW:0]   qCount;

  txRingData #(.AW(AW), .PW(PW), .QD(QD)) i_data (
    .clk(clk), .rstN(rstN),
    .baseWrEn(baseWrEn), .baseIn(baseIn),
    .lenWrEn(lenWrEn), .lenIn(lenIn),
    .tailWrEn(tailWrEn), .tailIn(tailIn),
    .rdDesc(txDesc_t'(descRdData)), .stb(stb),
    .rdAddr(descRdAddr), .wbAddr(wbAddr),
    .headIdx(head), .ringLen(ringLen),
    .fetchNeed(fetchNeed), .qFull(qFull), .qEmpty(qEmpty),
    .qCount(qCount), .qHead(qHead), .ctxSetting(bufCtx),
    .tailErr(tailErr), .eopIrq(eopIrq)
  );

  txRingCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .flush(lenWrEn),
    .fetchNeed(fetchNeed), .qFull(qFull), .qEmpty(qEmpty), .qHead(qHead),
    .rdAck(descRdAck), .bufAck(bufAck), .wbAck(wbAck),
    .rdReq(descRdReq), .bufReq(bufReq), .wbReq(wbReq), .stb(stb)
  );

  assign bufAddr = qHead.addr;
  assign bufLen  = qHead.len;
  assign bufEop  = qHead.eop;

endmodule

// File: rtl/txRingChecker.sv
module txRingChecker #(
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int QD = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [PW-1:0]       head,
  input logic [PW-1:0]       ringLen,
  input logic [$clog2(QD):0] qCount,
  input logic                descRdReq,
  input logic                bufReq,
  input logic                bufAck,
  input logic [31:0]         bufAddr,
  input logic                wbReq,
  input logic                eopIrq,
  input logic                tailWrEn,
  input logic [PW-1:0]       tailIn,
  input logic                tailErr,
  input logic                lenWrEn
);
  localparam int QW = $clog2(QD);

  function automatic logic [PW-1:0] wrapNext(input logic [PW-1:0] p, input logic [PW-1:0] n);
    return (p == n - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assert_bad_tail_R3: assert property (@(posedge clk) disable iff (!rstN)
    tailWrEn && !lenWrEn && (tailIn >= ringLen) |=> tailErr);

  assert_no_fetch_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == (QW+1)'(QD)) |-> !descRdReq);

  assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufReq && !bufAck && !lenWrEn |=> bufReq && $stable(bufAddr));

  assert_wb_after_buf_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbReq) |-> $past(bufReq) && $past(bufAck));

  assert_head_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ringLen != '0) |-> (head < ringLen));

  assert_head_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lenWrEn) && (head != $past(head)) |-> (head == wrapNext($past(head), ringLen)));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    eopIrq |=> !eopIrq);

endmodule

bind txRingEngine txRingChecker #(.AW(AW), .PW(PW), .QD(QD)) i_chk (
  .clk(clk), .rstN(rstN), .head(head), .ringLen(ringLen), .qCount(qCount),
  .descRdReq(descRdReq), .bufReq(bufReq), .bufAck(bufAck), .bufAddr(bufAddr),
  .wbReq(wbReq), .eopIrq(eopIrq), .tailWrEn(tailWrEn), .tailIn(tailIn),
  .tailErr(tailErr), .lenWrEn(lenWrEn)
);

// File: tb/test_txRingEngine.sv
module test_txRingEngine;
  localparam int AW = 32;
  localparam int PW = 8;
  localparam int RING = 12;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseWrEn = 0, lenWrEn = 0, tailWrEn = 0;
  logic [AW-1:0] baseIn = '0;
  logic [PW-1:0] lenIn = '0, tailIn = '0;
  logic descRdReq, descRdAck, bufReq, bufAck, wbReq, wbAck, bufEop, tailErr, eopIrq;
  logic [AW-1:0] descRdAddr, wbAddr;
  logic [63:0] descRdData;
  logic [31:0] bufAddr, bufCtx;
  logic [15:0] bufLen;
  logic [PW-1:0] head;

  always #10 clk = ~clk;

  txRingEngine #(.AW(AW), .PW(PW), .QD(8)) i_txRingEngine (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseIn(baseIn),
    .lenWrEn(lenWrEn), .lenIn(lenIn), .tailWrEn(tailWrEn), .tailIn(tailIn),
    .descRdReq(descRdReq), .descRdAddr(descRdAddr), .descRdAck(descRdAck),
    .descRdData(descRdData), .bufReq(bufReq), .bufAddr(bufAddr), .bufLen(bufLen),
    .bufEop(bufEop), .bufCtx(bufCtx), .bufAck(bufAck), .wbReq(wbReq),
    .wbAddr(wbAddr), .wbAck(wbAck), .head(head), .tailErr(tailErr), .eopIrq(eopIrq)
  );

  int testCnt = 0, failCnt = 0;
  int rdSeen = 0, irqSeen = 0, irqExp = 0;
  int ptrModel = 0;
  logic [31:0] ctxModel = '0;
  logic bufStall = 1'b0;
  logic irqPrev = 1'b0;
  logic [63:0] mem [RING];

  typedef struct packed { logic [31:0] addr; logic [15:0] len; logic eop; logic [31:0] ctx; } bufItem_t;
  logic [31:0] rdExp[$];
  logic [31:0] wbExp[$];
  bufItem_t    bufExp[$];

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkData(input logic [31:0] a, input logic [15:0] l, input logic e, input logic r);
    return {1'b1 ^ 1'b1, 13'd0, r, e, l, a};
  endfunction

  function automatic logic [63:0] mkCtx(input logic [31:0] v);
    return {1'b1, 13'd0, 1'b0, 1'b0, 16'd0, v};
  endfunction

  // scoreboard driver: predicts every read, buffer, write-back and interrupt
  task automatic kickTail(input int newTail);
    while (ptrModel != newTail) begin
      logic [63:0] d;
      d = mem[ptrModel];
      rdExp.push_back(BASE + 32'(ptrModel * 16));
      if (d[63]) ctxModel = d[31:0];
      else begin
        bufExp.push_back('{addr: d[31:0], len: d[47:32], eop: d[48], ctx: ctxModel});
        if (d[49]) wbExp.push_back(BASE + 32'(ptrModel * 16));
        if (d[48]) irqExp++;
      end
      ptrModel = (ptrModel + 1) % RING;
    end
    @(negedge clk);
    tailWrEn = 1'b1; tailIn = PW'(newTail);
    @(negedge clk);
    tailWrEn = 1'b0;
  endtask

  task automatic drain;
    while (rdExp.size() != 0 || bufExp.size() != 0 || wbExp.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // host model and monitor
  initial begin
    descRdAck = 0; bufAck = 0; wbAck = 0; descRdData = '0;
    forever begin
      @(negedge clk);
      descRdAck = 0; bufAck = 0; wbAck = 0;
      if (rstN && descRdReq) begin
        int slot;
        slot = int'((descRdAddr - BASE) >> 4) % RING;
        if (rdExp.size() == 0) check("R2", "unexpected descriptor read", descRdAddr, 64'hFFFF_FFFF);
        else check("R2", "descriptor read address", descRdAddr, rdExp.pop_front());
        descRdData = mem[slot];
        descRdAck = 1; rdSeen++;
      end
      if (rstN && bufReq && !bufStall) begin
        if (bufExp.size() == 0) check("R5", "unexpected buffer request", bufAddr, 64'hFFFF_FFFF);
        else begin
          bufItem_t e;
          e = bufExp.pop_front();
          check("R5", "buffer address", bufAddr, e.addr);
          check("R5", "buffer length", bufLen, e.len);
          check("R9", "buffer end flag", bufEop, e.eop);
          check("R6", "offload setting", bufCtx, e.ctx);
        end
        bufAck = 1;
      end
      if (rstN && wbReq) begin
        if (wbExp.size() == 0) check("R7", "unexpected write-back", wbAddr, 64'hFFFF_FFFF);
        else check("R7", "write-back address", wbAddr, wbExp.pop_front());
        wbAck = 1;
      end
      if (rstN && eopIrq) begin
        irqSeen++;
        if (irqPrev) check("R9", "interrupt longer than one cycle", 1, 0);
      end
      irqPrev = eopIrq;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    failCnt++; testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < RING; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "head at reset", head, 0);
    check("R1", "read request at reset", descRdReq, 0);
    check("R1", "buffer request at reset", bufReq, 0);
    check("R1", "write-back at reset", wbReq, 0);
    check("R1", "interrupt at reset", eopIrq, 0);
    check("R1", "tail error at reset", tailErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    lenWrEn = 1; lenIn = PW'(RING); baseWrEn = 1; baseIn = BASE;
    @(negedge clk);
    lenWrEn = 0; baseWrEn = 0;

    // round 1: context then a two-packet burst (R2, R5, R6, R7, R9)
    mem[0] = mkCtx(32'hA5A5_0001);
    mem[1] = mkData(32'h2000, 16'd64, 1'b0, 1'b0);
    mem[2] = mkData(32'h3000, 16'd100, 1'b1, 1'b1);
    mem[3] = mkData(32'h4000, 16'd20, 1'b1, 1'b0);
    kickTail(4);
    drain();
    check("R8", "head after first burst", head, 4);
    check("R9", "interrupts after first burst", irqSeen, irqExp);

    // R3 out-of-range tail
    @(negedge clk);
    tailWrEn = 1; tailIn = PW'(20);
    @(negedge clk);
    tailWrEn = 0;
    check("R3", "error flag after bad tail", tailErr, 1);
    repeat (10) @(negedge clk);
    check("R3", "no read after bad tail", descRdReq, 0);
    check("R3", "head unchanged after bad tail", head, 4);
    check("R3", "read count unchanged", rdSeen, 4);

    // round 2: wrap past slot 0 with buffers stalled (R4, R6, R8)
    mem[4]  = mkData(32'h5000, 16'd8,  1'b0, 1'b1);
    mem[5]  = mkData(32'h5100, 16'd16, 1'b1, 1'b0);
    mem[6]  = mkData(32'h5200, 16'd24, 1'b0, 1'b0);
    mem[7]  = mkData(32'h5300, 16'd32, 1'b1, 1'b1);
    mem[8]  = mkCtx(32'h0000_0BEE);
    mem[9]  = mkData(32'h6000, 16'd40, 1'b1, 1'b0);
    mem[10] = mkData(32'h6100, 16'd48, 1'b0, 1'b1);
    mem[11] = mkData(32'h6200, 16'd56, 1'b1, 1'b0);
    mem[0]  = mkData(32'h6300, 16'd64, 1'b0, 1'b0);
    mem[1]  = mkData(32'h6400, 16'd72, 1'b1, 1'b1);
    bufStall = 1'b1;
    kickTail(2);
    check("R3", "error flag cleared by good tail", tailErr, 0);
    repeat (40) @(negedge clk);
    check("R4", "reads while queue full", rdSeen - 4, 8);
    check("R4", "no read request while full", descRdReq, 0);
    check("R8", "head held while buffer stalls", head, 4);
    bufStall = 1'b0;
    drain();
    check("R8", "head wrapped to slot 2", head, 2);
    check("R9", "total interrupts", irqSeen, irqExp);
    check("R2", "total descriptor reads", rdSeen, 14);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule